// File: doc/BRIEF.md
# Quadrature Oscillator with Complex Multiply-Accumulate

This block is a complex numerically controlled oscillator whose rotating (cos, sin) vector drives a complex multiplier and an accumulator. A 32-bit phase register advances by a programmable frequency word on every enabled clock. The top 16 bits of that phase, plus a 16-bit phase offset, form the argument of a pipelined CORDIC rotator. The rotator produces cosine and sine with a signed 16-bit amplitude.

Each complex input sample travels through a delay line next to the rotator, so it meets the vector that was computed from the same clock. The sample is then multiplied by that vector. The complex product either restarts the running sum or is added to it, which gives an accumulate-and-dump filter. The sum is rounded and clamped to two 20-bit outputs. To down-convert, load the carrier frequency as the frequency word and feed the received samples into the complex input.

Top module: `quad_nco_cmac`

## Requirements
- R1: When `f_ld` is high, the frequency register takes `f_word` at the clock edge. On each edge where `en` is high and `clr` is low, the 32-bit phase accumulator adds the frequency register value it held before that edge, wrapping modulo 2^32. When `en` is low, the phase accumulator holds.
- R2: When `p_ld` is high, the phase-offset register takes `p_word`. The rotator argument is `(phase[31:16] + offset) mod 2^16`, where 2^16 counts as one full turn.
- R3: `clr` zeroes the phase accumulator at the next edge and takes priority over `en`.
- R4: The vector is bit-exact as follows. When argument bits [15:14] are 01 or 10, bit 15 is inverted and the result is negated at the end. The folded argument, read as signed, times 16 is the start angle, in units of 2^-20 turn. The start point is x=19895, y=0. Sixteen rotations follow, each using arithmetic shifts by the iteration index and the package arctangent constants. The direction of each rotation follows the sign of the residual angle. Both x and y are clamped to ±32767, giving cos = x and sin = y.
- R5: The product is re = xr·cos − xi·sin and im = xr·sin + xi·cos, both computed at full precision.
- R6: Each output is (sum + 2^14) arithmetically shifted right by 15, then clamped to [−524288, 524287].
- R7: For a valid sample with `in_acc` low, the running sum is loaded with the product. With `in_acc` high, the product is added to the running sum.
- R8: A sample with `in_vld` low changes neither the sum nor the outputs, and its result has `out_vld` low.
- R9: A sample captured at edge t appears on the outputs, with `out_vld` high, at edge t+18.
- R10: Synchronous reset clears all registers: the outputs are zero and `out_vld` is low.
- R11: A phase offset of 0x8000 negates the vector. The result for a given sample equals, within one LSB, the negation of the result with offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Phase advance enable |
| clr | input | 1 | Zero the phase accumulator |
| f_ld | input | 1 | Frequency word load strobe |
| f_word | input | 32 | Frequency word |
| p_ld | input | 1 | Phase offset load strobe |
| p_word | input | 16 | Phase offset word |
| in_vld | input | 1 | Input sample valid |
| in_acc | input | 1 | Accumulate (1) or restart (0) |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| out_re | output | 20 | Result real part, signed |
| out_im | output | 20 | Result imaginary part, signed |
| out_vld | output | 1 | Result valid |

## Verification
The bench targets these corner cases and the failure each one would expose:
- Zero frequency: a design that still advances the phase would make the zero-frequency vector drift.
- Nyquist-rate word: wrong handling of the quadrant fold at exactly 180° would break the output that alternates sign every sample.
- Half-cycle offset: a design that folds on the wrong bits, or negates twice, would fail to mirror the zero-offset result.
- Long accumulation runs: these force the clamp, and a design that wraps instead of saturating would flip sign.
- Gaps in the valid flag: a design that let invalid samples into the sum would make the output drift or change during a gap.
- Clear pulses and a latency measurement: these catch a delay line that is one stage off, so samples would pair with the wrong vector.

// File: rtl/qnc_pkg.sv
package qnc_pkg;
    localparam int FW      = 32;          // phase accumulator width
    localparam int PW      = 16;          // rotator argument width
    localparam int SW      = 16;          // sample and vector width
    localparam int OW      = 20;          // result width
    localparam int ITER    = 16;          // rotation stages
    localparam int ZW      = PW + 4;      // residual angle width
    localparam int XYW     = SW + 4;      // rotator datapath width
    localparam int PRW     = 2 * SW + 1;  // complex product width
    localparam int AW      = PRW + 7;     // running sum width
    localparam int FRAC    = SW - 1;      // vector fraction bits
    localparam int AMP     = (1 << (SW - 1)) - 1;
    localparam int X_START = 19895;       // AMP divided by rotator gain

    typedef logic signed [SW-1:0] samp_t;

    typedef struct packed {
        logic  vld;
        logic  acc;
        samp_t re;
        samp_t im;
    } side_t;

    typedef struct packed {
        logic signed [XYW-1:0] x;
        logic signed [XYW-1:0] y;
        logic signed [ZW-1:0]  z;
        logic                  neg;
        side_t                 sd;
    } rot_t;

    // arctangent of 2^-i in units of 2^-20 turn
    function automatic logic signed [ZW-1:0] atan_step(input int i);
        case (i)
            0:  return ZW'(131072);
            1:  return ZW'(77376);
            2:  return ZW'(40883);
            3:  return ZW'(20753);
            4:  return ZW'(10417);
            5:  return ZW'(5213);
            6:  return ZW'(2607);
            7:  return ZW'(1304);
            8:  return ZW'(652);
            9:  return ZW'(326);
            10: return ZW'(163);
            11: return ZW'(81);
            12: return ZW'(41);
            13: return ZW'(20);
            14: return ZW'(10);
            15: return ZW'(5);
            default: return '0;
        endcase
    endfunction

    function automatic samp_t clamp_amp(input logic signed [XYW-1:0] v);
        logic signed [XYW-1:0] lim;
        lim = XYW'(AMP);
        if (v > lim)       return samp_t'(AMP);
        else if (v < -lim) return samp_t'(-AMP);
        else               return v[SW-1:0];
    endfunction

    function automatic logic signed [OW-1:0] round_sat(input logic signed [AW-1:0] v);
        logic signed [AW-1:0] half, r, hi, lo;
        half = AW'(1) <<< (FRAC - 1);
        hi   = AW'((1 << (OW - 1)) - 1);
        lo   = -hi - AW'(1);
        r    = (v + half) >>> FRAC;
        if (r > hi)      return hi[OW-1:0];
        else if (r < lo) return lo[OW-1:0];
        else             return r[OW-1:0];
    endfunction
endpackage

// File: rtl/qnc_phase.sv
module qnc_phase import qnc_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    input  logic          f_ld,
    input  logic [FW-1:0] f_word,
    input  logic          p_ld,
    input  logic [PW-1:0] p_word,
    output logic [PW-1:0] arg
);
    logic [FW-1:0] f_q;
    logic [FW-1:0] acc_q;
    logic [PW-1:0] p_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q   <= '0;
            p_q   <= '0;
            acc_q <= '0;
        end else begin
            if (f_ld) f_q <= f_word;
            if (p_ld) p_q <= p_word;
            if (clr)     acc_q <= '0;
            else if (en) acc_q <= acc_q + f_q;
        end
    end

    assign arg = acc_q[FW-1 -: PW] + p_q;

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    // R1
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && (!en || f_q == '0) && !f_ld) |=> $stable(acc_q));
endmodule

// File: rtl/qnc_rot_stage.sv
module qnc_rot_stage import qnc_pkg::*; #(
    parameter int IDX = 0
) (
    input  logic clk,
    input  logic rst,
    input  rot_t d,
    output rot_t q
);
    rot_t                  nx;
    logic signed [XYW-1:0] xs;
    logic signed [XYW-1:0] ys;

    always_comb begin
        xs = d.x >>> IDX;
        ys = d.y >>> IDX;
        nx = d;
        if (!d.z[ZW-1]) begin
            nx.x = d.x - ys;
            nx.y = d.y + xs;
            nx.z = d.z - atan_step(IDX);
        end else begin
            nx.x = d.x + ys;
            nx.y = d.y - xs;
            nx.z = d.z + atan_step(IDX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nx;
    end
endmodule

// File: rtl/qnc_cordic.sv
module qnc_cordic import qnc_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] arg,
    input  side_t         sd_in,
    output samp_t         cos_o,
    output samp_t         sin_o,
    output side_t         sd_o
);
    rot_t          st0;
    rot_t          chain [ITER+1];
    rot_t          fin;
    logic          flip;
    logic [PW-1:0] folded;

    assign flip   = arg[PW-1] ^ arg[PW-2];
    assign folded = {arg[PW-1] ^ flip, arg[PW-2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st0 <= '0;
        end else begin
            st0.x   <= XYW'(X_START);
            st0.y   <= '0;
            st0.z   <= {folded, {(ZW-PW){1'b0}}};
            st0.neg <= flip;
            st0.sd  <= sd_in;
        end
    end

    assign chain[0] = st0;

    generate
        for (genvar g = 0; g < ITER; g++) begin : g_stage
            qnc_rot_stage #(.IDX(g)) u_stage (
                .clk (clk),
                .rst (rst),
                .d   (chain[g]),
                .q   (chain[g+1])
            );
        end
    endgenerate

    assign fin   = chain[ITER];
    assign cos_o = fin.neg ? -clamp_amp(fin.x) : clamp_amp(fin.x);
    assign sin_o = fin.neg ? -clamp_amp(fin.y) : clamp_amp(fin.y);
    assign sd_o  = fin.sd;

    localparam longint MAG_NOM = longint'(AMP) * longint'(AMP);
    localparam logic signed [2*SW:0] MAG_LO = (2*SW+1)'(MAG_NOM - MAG_NOM / 64);
    localparam logic signed [2*SW:0] MAG_HI = (2*SW+1)'(MAG_NOM + MAG_NOM / 64);
    logic signed [2*SW:0] cw, sw, mag;
    assign cw  = (2*SW+1)'(cos_o);
    assign sw  = (2*SW+1)'(sin_o);
    assign mag = cw * cw + sw * sw;

    // R4
    vec_mag_chk: assert property (@(posedge clk) disable iff (rst)
        fin.sd.vld |-> (mag > MAG_LO && mag < MAG_HI));

    // R4
    angle_conv_chk: assert property (@(posedge clk) disable iff (rst)
        fin.sd.vld |-> (fin.z < ZW'(64) && fin.z > -ZW'(64)));
endmodule

// File: rtl/qnc_mac.sv
module qnc_mac import qnc_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  samp_t                c,
    input  samp_t                s,
    input  side_t                sd,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im,
    output logic                 out_vld
);
    logic signed [PRW-1:0] xr, xi, cw, sw;
    logic signed [PRW-1:0] p_re_n, p_im_n;
    logic signed [PRW-1:0] p_re, p_im;
    logic                  p_vld, p_acc;
    logic signed [AW-1:0]  sum_re, sum_im, nx_re, nx_im;

    assign xr     = PRW'(sd.re);
    assign xi     = PRW'(sd.im);
    assign cw     = PRW'(c);
    assign sw     = PRW'(s);
    assign p_re_n = xr * cw - xi * sw;
    assign p_im_n = xr * sw + xi * cw;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_re  <= '0;
            p_im  <= '0;
            p_vld <= 1'b0;
            p_acc <= 1'b0;
        end else begin
            p_re  <= p_re_n;
            p_im  <= p_im_n;
            p_vld <= sd.vld;
            p_acc <= sd.acc;
        end
    end

    assign nx_re = p_acc ? sum_re + AW'(p_re) : AW'(p_re);
    assign nx_im = p_acc ? sum_im + AW'(p_im) : AW'(p_im);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_re  <= '0;
            sum_im  <= '0;
            out_re  <= '0;
            out_im  <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= p_vld;
            if (p_vld) begin
                sum_re <= nx_re;
                sum_im <= nx_im;
                out_re <= round_sat(nx_re);
                out_im <= round_sat(nx_im);
            end
        end
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !p_vld |=> ($stable(out_re) && $stable(out_im) && !out_vld));

    // R9
    vld_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(p_vld));
endmodule

// File: rtl/quad_nco_cmac.sv
module quad_nco_cmac import qnc_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 clr,
    input  logic                 f_ld,
    input  logic [31:0]          f_word,
    input  logic                 p_ld,
    input  logic [15:0]          p_word,
    input  logic                 in_vld,
    input  logic                 in_acc,
    input  logic signed [15:0]   in_re,
    input  logic signed [15:0]   in_im,
    output logic signed [19:0]   out_re,
    output logic signed [19:0]   out_im,
    output logic                 out_vld
);
    logic [PW-1:0] arg;
    side_t         sd_in, sd_al;
    samp_t         cos_v, sin_v;

    assign sd_in = '{vld: in_vld, acc: in_acc, re: in_re, im: in_im};

    qnc_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .clr    (clr),
        .f_ld   (f_ld),
        .f_word (f_word),
        .p_ld   (p_ld),
        .p_word (p_word),
        .arg    (arg)
    );

    qnc_cordic u_cordic (
        .clk   (clk),
        .rst   (rst),
        .arg   (arg),
        .sd_in (sd_in),
        .cos_o (cos_v),
        .sin_o (sin_v),
        .sd_o  (sd_al)
    );

    qnc_mac u_mac (
        .clk     (clk),
        .rst     (rst),
        .c       (cos_v),
        .s       (sin_v),
        .sd      (sd_al),
        .out_re  (out_re),
        .out_im  (out_im),
        .out_vld (out_vld)
    );
endmodule

// File: tb/quad_nco_cmac_tb_top.sv
`timescale 1ns/1ps
module quad_nco_cmac_tb_top;
    import qnc_pkg::atan_step;

    localparam int LAT = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, clr = 1'b0, f_ld = 1'b0, p_ld = 1'b0;
    logic [31:0] f_word = '0;
    logic [15:0] p_word = '0;
    logic in_vld = 1'b0, in_acc = 1'b0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic signed [19:0] out_re, out_im;
    logic out_vld;

    always #2 clk = ~clk;

    quad_nco_cmac dut_i (
        .clk(clk), .rst(rst), .en(en), .clr(clr),
        .f_ld(f_ld), .f_word(f_word), .p_ld(p_ld), .p_word(p_word),
        .in_vld(in_vld), .in_acc(in_acc), .in_re(in_re), .in_im(in_im),
        .out_re(out_re), .out_im(out_im), .out_vld(out_vld)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 0;
    bit done = 0;
    string cur_req = "R10";

    task automatic report(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { bit v; bit a; longint pr; longint pi; } ent_t;
    ent_t   pipe_q[$];
    longint m_acc, m_f, m_pm, m_sr, m_si;
    int     exp_re, exp_im;
    bit     exp_vld;

    function automatic void ref_vec(input int arg, output int c, output int s);
        int a, x, y, z, xs, ys, q;
        bit ng;
        q  = (arg >> 14) & 3;
        ng = (q == 1) || (q == 2);
        a  = ng ? (arg ^ 32768) : arg;
        if (a >= 32768) a -= 65536;
        z = a * 16; x = 19895; y = 0;
        for (int i = 0; i < 16; i++) begin
            xs = x >>> i; ys = y >>> i;
            if (z >= 0) begin x -= ys; y += xs; z -= int'(atan_step(i)); end
            else        begin x += ys; y -= xs; z += int'(atan_step(i)); end
        end
        if (x > 32767) x = 32767; if (x < -32767) x = -32767;
        if (y > 32767) y = 32767; if (y < -32767) y = -32767;
        c = ng ? -x : x;
        s = ng ? -y : y;
    endfunction

    function automatic int ref_round(input longint v);
        longint r;
        r = (v + 16384) >>> 15;
        if (r > 524287)  r = 524287;
        if (r < -524288) r = -524288;
        return int'(r);
    endfunction

    always @(posedge clk) begin
        int c, s;
        ent_t e, o;
        if (rst) begin
            pipe_q.delete();
            m_acc = 0; m_f = 0; m_pm = 0; m_sr = 0; m_si = 0;
            exp_re = 0; exp_im = 0; exp_vld = 0;
        end else begin
            ref_vec(int'(((m_acc >> 16) + m_pm) & 65535), c, s);
            e.v  = in_vld;
            e.a  = in_acc;
            e.pr = longint'(in_re) * c - longint'(in_im) * s;
            e.pi = longint'(in_re) * s + longint'(in_im) * c;
            pipe_q.push_back(e);
            if (pipe_q.size() > LAT) begin
                o = pipe_q.pop_front();
                if (o.v) begin
                    m_sr = o.a ? m_sr + o.pr : o.pr;
                    m_si = o.a ? m_si + o.pi : o.pi;
                    exp_re = ref_round(m_sr);
                    exp_im = ref_round(m_si);
                    exp_vld = 1;
                end else begin
                    exp_vld = 0;
                end
            end
            if (clr)     m_acc = 0;
            else if (en) m_acc = (m_acc + m_f) & 64'hFFFF_FFFF;
            if (f_ld) m_f  = longint'(f_word);
            if (p_ld) m_pm = longint'(p_word);
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            n_chk++;
            if (out_vld !== exp_vld || int'(out_re) != exp_re || int'(out_im) != exp_im) begin
                n_bad++;
                $display("FAIL %s cycle compare actual=(%0d,%0d,v%0d) expected=(%0d,%0d,v%0d)",
                         cur_req, out_re, out_im, out_vld, exp_re, exp_im, exp_vld);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input bit v, input bit a, input int re, input int im);
        in_vld = v; in_acc = a; in_re = 16'(re); in_im = 16'(im);
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic load_f(input logic [31:0] w);
        f_ld = 1'b1; f_word = w;
        @(negedge clk);
        f_ld = 1'b0;
    endtask

    task automatic load_p(input logic [15:0] w);
        p_ld = 1'b1; p_word = w;
        @(negedge clk);
        p_ld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int a_re, a_im, k;
        repeat (3) @(negedge clk);
        // R10: reset state
        report("R10", "out_vld in reset", out_vld, 0);
        report("R10", "out_re in reset", out_re, 0);
        report("R10", "out_im in reset", out_im, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_on = 1;

        // R5: zero frequency, stationary vector
        cur_req = "R5";
        load_f(32'h0); en = 1'b1;
        for (int i = 0; i < 40; i++) step(1, 0, rnd16(), rnd16());

        // R1: rotating vector
        cur_req = "R1";
        load_f(32'h0400_0000);
        for (int i = 0; i < 80; i++) step(1, 0, rnd16(), rnd16());
        en = 1'b0;
        for (int i = 0; i < 20; i++) step(1, 0, rnd16(), rnd16());
        en = 1'b1;

        // R4: arbitrary word visits all quadrants
        cur_req = "R4";
        load_f(32'h0123_4567);
        for (int i = 0; i < 120; i++) step(1, 0, rnd16(), rnd16());

        // R1: Nyquist-rate word
        cur_req = "R1";
        load_f(32'h8000_0000);
        for (int i = 0; i < 60; i++) step(1, 0, rnd16(), rnd16());

        // R2: phase offset modulation
        cur_req = "R2";
        load_f(32'h0010_0000);
        for (int i = 0; i < 40; i++) begin
            if (i % 8 == 0) load_p(16'($urandom));
            step(1, 0, rnd16(), rnd16());
        end

        // R7: accumulate and dump
        cur_req = "R7";
        for (int i = 0; i < 80; i++) step(1, (i % 5) != 0, rnd16() / 8, rnd16() / 8);

        // R8: gaps in valid
        cur_req = "R8";
        for (int i = 0; i < 80; i++) step($urandom_range(0, 1), $urandom_range(0, 1), rnd16(), rnd16());

        // R3: clear pulses while enabled
        cur_req = "R3";
        for (int i = 0; i < 60; i++) begin
            clr = (i % 13 == 4);
            step(1, 0, rnd16(), rnd16());
        end
        clr = 1'b0;

        // R6: long accumulation forces the clamp
        cur_req = "R6";
        clr = 1'b1; load_f(32'h0); load_p(16'h0); clr = 1'b0;
        step(1, 0, 32767, 0);
        for (int i = 0; i < 19; i++) step(1, 1, 32767, 0);
        idle(LAT + 2);
        report("R6", "positive clamp", out_re, 524287);
        step(1, 0, -32767, 0);
        for (int i = 0; i < 19; i++) step(1, 1, -32767, 0);
        idle(LAT + 2);
        report("R6", "negative clamp", out_re, -524288);

        // R11: half-cycle phase offset negates the result
        cur_req = "R11";
        step(1, 0, 12000, -5000);
        idle(LAT + 2);
        a_re = out_re; a_im = out_im;
        load_p(16'h8000);
        step(1, 0, 12000, -5000);
        idle(LAT + 2);
        report("R11", "nonzero reference", (a_re != 0), 1);
        report("R11", "re mirrored", ((a_re + out_re) <= 1 && (a_re + out_re) >= -1), 1);
        report("R11", "im mirrored", ((a_im + out_im) <= 1 && (a_im + out_im) >= -1), 1);

        // R9: latency from capture to output
        cur_req = "R9";
        idle(4);
        in_vld = 1'b1; in_acc = 1'b0; in_re = 16'sd1000; in_im = 16'sd0;
        @(negedge clk);
        in_vld = 1'b0;
        k = 1;
        while (!out_vld && k < 40) begin
            @(negedge clk);
            k++;
        end
        report("R9", "negedges until out_vld", k, LAT + 1);

        idle(LAT + 4);
        summary();
    end
endmodule